// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a serial peripheral interface master from a faster module clock. A configuration word holds two divider fields and a select bit. One field gives a linear division by an even integer and the other gives a division by a power of two. The select bit picks which of the two drives the output. The output always has a 50% duty cycle.

A shift engine uses the block through its `run` input. While `run` is low, the serial clock rests at the idle level given by `cpol` and the counter is cleared. While `run` is high, the clock toggles. Every toggle comes with a one-cycle strobe: `leadStb` when the clock leaves its idle level and `trailStb` when it returns to it. The shift engine shifts and samples on these strobes, so it needs no edge detector of its own.

The configuration word and the polarity are captured while `run` is low and are frozen for the whole burst. A change made mid-transfer therefore never produces a shortened or stretched period.

Top module: `spi_clk_div`

## Requirements
- R1: With `divCfg[12]`=1 (linear mode), the half period is N+1 module cycles, where N=`divCfg[7:0]`. The serial clock frequency is therefore the module clock divided by 2*(N+1).
- R2: With `divCfg[12]`=0 (power-of-two mode), the half period is 2^M module cycles, where M=`divCfg[11:8]`. The serial clock frequency is therefore the module clock divided by 2^(M+1).
- R3: Only the field chosen by `divCfg[12]` affects the output; the other field is ignored.
- R4: While `run` is sampled low, `sclk` equals the `cpol` value sampled at the same rising edge, with both strobes low. After `run` is sampled high at rising edge 0, the first toggle of `sclk` occurs at rising edge H-1, where H is the half period. Later toggles follow every H edges.
- R5: `leadStb` is high for exactly the cycle in which `sclk` moves away from its idle level. `trailStb` is high for exactly the cycle in which `sclk` returns to it. The two are never high together.
- R6: N=0 in linear mode, or M=0 in power-of-two mode, gives the fastest output: `sclk` toggles on every module cycle, and the lead and trail strobes alternate.
- R7: Changes to `divCfg` or `cpol` while `run` is high have no effect on the current burst. The values present at the last rising edge with `run` low apply.
- R8: If `run` falls in the cycle in which a toggle is due, the drop takes priority. `sclk` goes to the idle level with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High while a transfer is in progress |
| cpol | input | 1 | Idle level of the serial clock |
| divCfg | input | 13 | [7:0] linear field, [11:8] exponent field, [12] mode select (1 = linear) |
| sclk | output | 1 | Serial clock |
| leadStb | output | 1 | One-cycle strobe with the edge leaving idle |
| trailStb | output | 1 | One-cycle strobe with the edge returning to idle |

## Verification
Two functions can act in the same cycle.

The first pair is the end of a burst and a due toggle. The bench sets the burst length so that `run` drops exactly on the edge where the counter reaches its terminal count. It expects `sclk` at the idle level with both strobes low, instead of a trailing edge.

The second pair is a reconfiguration and a running burst. The bench changes `divCfg` and `cpol` mid-burst and still expects the original period and edge directions. The new values must appear only once `run` has gone low.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  typedef struct packed {
    logic active;   // run is high
    logic tick;     // half period complete this cycle
    logic pol;      // polarity captured for the burst
    logic idleLvl;  // live idle level while not running
  } divCtl_t;
endpackage

// File: rtl/spi_div_ctl.sv
module spi_div_ctl
  import spi_clk_div_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 cpol,
  input  logic [N_W+M_W:0]     divCfg,
  output divCtl_t              ctl
);
  localparam int HALF_W = 1 << M_W;
  localparam int SEL_B  = N_W + M_W;

  logic [HALF_W-1:0] termQ;
  logic [HALF_W-1:0] termNext;
  logic [HALF_W-1:0] cnt;
  logic              polQ;
  logic              atTerm;

  always_comb begin
    if (divCfg[SEL_B])
      termNext = HALF_W'(divCfg[N_W-1:0]);
    else
      termNext = (HALF_W'(1) << divCfg[SEL_B-1:N_W]) - HALF_W'(1);
  end

  // configuration tracks the inputs while idle and freezes during a burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termQ <= '0;
      polQ  <= 1'b0;
    end else if (!run) begin
      termQ <= termNext;
      polQ  <= cpol;
    end
  end

  assign atTerm = (cnt == termQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (atTerm)      cnt <= '0;
    else                  cnt <= cnt + HALF_W'(1);
  end

  assign ctl.active  = run;
  assign ctl.tick    = run && atTerm;
  assign ctl.pol     = polQ;
  assign ctl.idleLvl = cpol;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termQ);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && termQ != '0) |=> !ctl.tick);

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run)) |-> ($stable(termQ) && $stable(polQ)));
endmodule

// File: rtl/spi_div_dp.sv
module spi_div_dp
  import spi_clk_div_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    sclk,
  output logic    leadStb,
  output logic    trailStb
);
  logic phase;  // 1 while sclk sits away from idle

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      sclk     <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else if (!ctl.active) begin
      phase    <= 1'b0;
      sclk     <= ctl.idleLvl;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else if (ctl.tick) begin
      phase    <= ~phase;
      sclk     <= ctl.pol ^ ~phase;
      leadStb  <= ~phase;
      trailStb <= phase;
    end else begin
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStb && trailStb));

  p_lead_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb || trailStb) |-> (sclk != $past(sclk)));

  p_no_strobe_after_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && !ctl.tick) |=> !leadStb);
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             cpol,
  input  logic [N_W+M_W:0] divCfg,
  output logic             sclk,
  output logic             leadStb,
  output logic             trailStb
);
  divCtl_t ctl;

  spi_div_ctl #(.N_W(N_W), .M_W(M_W)) i_ctl (
    .clk(clk), .rstN(rstN), .run(run), .cpol(cpol), .divCfg(divCfg), .ctl(ctl)
  );

  spi_div_dp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (sclk == $past(cpol)) && !leadStb && !trailStb);

  p_drop_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(run) && !run) |=> !trailStb);
endmodule

// File: tb/test_spi_clk_div.sv
module test_spi_clk_div;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  sclk;
    logic  lead;
    logic  trail;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic cpol = 1'b0;
  logic [12:0] divCfg = '0;
  logic sclk, leadStb, trailStb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  bit runSeen = 1'b0;
  bit cpolSeen = 1'b0;
  bit monOn   = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clk_div i_spi_clk_div (
    .clk(clk), .rstN(rstN), .run(run), .cpol(cpol), .divCfg(divCfg),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

  always @(posedge clk) begin
    runSeen  <= run;
    cpolSeen <= cpol;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares each cycle against the scoreboard or the idle rule
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (runSeen) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected running cycle", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(sclk == e.sclk, e.tag, "sclk", sclk, e.sclk);
          check(leadStb == e.lead, "R5", "leadStb", leadStb, e.lead);
          check(trailStb == e.trail, "R5", "trailStb", trailStb, e.trail);
        end
      end else begin
        check(sclk == cpolSeen && !leadStb && !trailStb, "R4",
              "idle sclk/strobes", {sclk, leadStb, trailStb}, {cpolSeen, 2'b00});
      end
    end
  end

  // driver: one burst, expected items derived from the half period
  task automatic burst(input bit linMode, input int fN, input int fM,
                       input bit pol, input int cycles, input int changeAt,
                       input string tag);
    int half;
    @(negedge clk);
    divCfg = {linMode, 4'(fM), 8'(fN)};
    cpol   = pol;
    @(negedge clk);
    half = linMode ? fN + 1 : (1 << fM);
    for (int i = 0; i < cycles; i++) begin
      expItem_t e;
      int t;
      bit edgeNow;
      t = (i + 1) / half;
      edgeNow = ((i + 1) % half) == 0;
      e.sclk  = pol ^ t[0];
      e.lead  = edgeNow && t[0];
      e.trail = edgeNow && !t[0];
      e.tag   = tag;
      expQ.push_back(e);
    end
    run = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (k == changeAt) begin
        divCfg = {~linMode, 4'd0, 8'd0};
        cpol   = ~pol;
      end
    end
    run = 1'b0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, tag, "items left in scoreboard", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !leadStb && !trailStb, "R4", "reset state",
          {sclk, leadStb, trailStb}, 0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    repeat (3) @(negedge clk);

    burst(1'b1, 2, 9, 1'b0, 30, -1, "R1");        // linear N=2, M field ignored (R3)
    burst(1'b0, 5, 2, 1'b1, 40, -1, "R2");        // pow M=2, N field ignored (R3)
    burst(1'b0, 200, 3, 1'b0, 70, -1, "R3");      // pow M=3 with large unused N
    burst(1'b1, 0, 7, 1'b0, 12, -1, "R6");        // fastest, linear
    burst(1'b0, 0, 0, 1'b1, 12, -1, "R6");        // fastest, power of two
    burst(1'b1, 255, 0, 1'b0, 600, -1, "R1");     // widest linear division
    burst(1'b1, 3, 0, 1'b0, 40, 5, "R7");         // reconfigure mid-burst
    burst(1'b1, 3, 0, 1'b1, 40, 18, "R7");        // reconfigure near an edge
    burst(1'b1, 2, 0, 1'b0, 5, -1, "R8");         // run drops as trailing edge is due
    burst(1'b0, 0, 1, 1'b1, 7, -1, "R8");         // power mode, drop on due edge

    // cpol changes while idle must reach sclk one cycle later
    @(negedge clk);
    cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R4", "idle follows cpol", sclk, 1);

    done = 1'b1;
    monOn = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule